// File: doc/BRIEF.md
# Weighted Fair Queueing Finish-Tag Scheduler

This block orders packet departures for a handful of flows by their virtual finish time. Every arriving packet carries a flow number and a length. The block gives it a virtual start tag and a finish tag, then appends the finish tag to a small tag queue kept for that flow. Packet data is stored elsewhere. Only the tags pass through this block.

The output link asks for the next packet with a single request line. In the same cycle the block looks at the head tag of every flow that holds packets and names the flow whose tag is smallest. It also returns that tag. At the next clock edge the head entry is removed. The virtual round number is computed outside the block and arrives on an input. A per-flow log2 weight scales each packet's length down, so a flow with a larger weight moves its tags forward more slowly and receives a larger share of the link.

Top module: `wfq_sched`

## Requirements
- R1: After reset every flow queue is empty, so a dequeue request returns `deq_valid` = 0.
- R2: A packet that arrives at a flow whose queue is empty takes `round_now` as its start tag.
- R3: A packet that arrives at a flow whose queue still holds entries takes that flow's most recent finish tag as its start tag.
- R4: The finish tag is the start tag plus the packet length shifted right by the flow's log2 weight. The weight of flow i is field `weight_log2[i*WSH_W +: WSH_W]`.
- R5: While `deq_req` is high and at least one flow holds entries, `deq_valid` is 1 in that same cycle. `deq_flow` and `deq_tag` then name the smallest head finish tag among the non-empty flows, and that entry is removed at the next rising edge.
- R6: When two or more non-empty flows have equal head finish tags, the flow with the lower index is served.
- R7: A dequeue request while every flow is empty returns `deq_valid` = 0 and changes no state.
- R8: An enqueue to a flow whose queue already holds DEPTH entries raises `enq_drop` in that cycle. The packet is discarded and the queue is left unchanged.
- R9: Each flow serves its own tags in arrival order. After a flow has fully drained, its next arrival again starts at `round_now` (R2), even when the previous finish tag is larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| weight_log2 | input | NUM_FLOWS*WSH_W | Per-flow log2 weight, packed with flow 0 in the low field |
| round_now | input | TAG_W | Current virtual round number |
| enq_valid | input | 1 | A packet arrives in this cycle |
| enq_flow | input | FLOW_W | Flow index of the arriving packet |
| enq_len | input | LEN_W | Length of the arriving packet |
| enq_drop | output | 1 | The arrival is discarded because its flow queue is full |
| deq_req | input | 1 | The link requests the next packet |
| deq_valid | output | 1 | A packet is chosen in this cycle |
| deq_flow | output | FLOW_W | Flow of the chosen packet |
| deq_tag | output | TAG_W | Finish tag of the chosen packet |

## Verification
The bench builds the block with four flows, a queue depth of four, 12-bit lengths and 16-bit tags. With a depth of four, a full queue and the drop on the fifth arrival (R8) take only a few cycles to reach. With four flows, the comparator tree has two full levels, so ties can be decided in both the leaf pairs and the root (R6). The 16-bit tags leave room for a long random phase with a rising round number and no tag wrap, so every finish tag can be predicted exactly from a reference model of queues.

// File: rtl/wfq_pkg.sv
// Shared helpers for the finish-tag scheduler.
// Assumes nothing beyond elaboration-time constant arguments.
package wfq_pkg;
    // Index width for a count of n items, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/wfq_flow_queue.sv
// Per-flow tag queue: a circular buffer of finish tags plus the flow's
// most recent finish tag. Assumes the parent never pushes when full
// and never pops when empty.
module wfq_flow_queue #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             pop,
    output logic [TAG_W-1:0] head_tag,
    output logic [TAG_W-1:0] last_fin,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = wfq_pkg::idx_bits(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

    logic [TAG_W-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign head_tag = store[rd_ptr];

    // Write the tag store on push.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_tag;
    end

    // Advance pointers, occupancy and the last finish tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            last_fin <= '0;
        end else begin
            if (push) begin
                wr_ptr   <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
                last_fin <= push_tag;
            end
            if (pop) rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/wfq_min_select.sv
// Combinational comparator tree that picks the smallest valid tag.
// Leaves beyond NUM_FLOWS are padded as invalid. On equal tags the left
// (lower-index) branch wins, so the lowest flow index is chosen.
module wfq_min_select #(
    parameter int unsigned NUM_FLOWS = 4,
    parameter int unsigned TAG_W     = 16,
    parameter int unsigned FLOW_W    = 2
) (
    input  logic [NUM_FLOWS-1:0]       vld,
    input  logic [NUM_FLOWS*TAG_W-1:0] tags,
    output logic                       any,
    output logic [FLOW_W-1:0]          win_idx,
    output logic [TAG_W-1:0]           win_tag
);
    localparam int unsigned LEAVES = 1 << FLOW_W;
    localparam int unsigned NODES  = 2 * LEAVES;

    logic [NODES-1:0]        nv;
    logic [NODES*TAG_W-1:0]  nt;
    logic [NODES*FLOW_W-1:0] ni;

    assign nv[0]            = 1'b0;
    assign nt[0 +: TAG_W]   = '0;
    assign ni[0 +: FLOW_W]  = '0;

    // Leaf level: one leaf per possible flow index.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_FLOWS) begin : g_real
            assign nv[LEAVES+i]                  = vld[i];
            assign nt[(LEAVES+i)*TAG_W +: TAG_W] = tags[i*TAG_W +: TAG_W];
        end else begin : g_pad
            assign nv[LEAVES+i]                  = 1'b0;
            assign nt[(LEAVES+i)*TAG_W +: TAG_W] = '0;
        end
        assign ni[(LEAVES+i)*FLOW_W +: FLOW_W] = FLOW_W'(i);
    end

    // Internal nodes: each keeps the smaller valid child, left on ties.
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic take_r;
        assign take_r = nv[2*n+1] &&
                        (!nv[2*n] || (nt[(2*n+1)*TAG_W +: TAG_W] < nt[(2*n)*TAG_W +: TAG_W]));
        assign nv[n] = nv[2*n] | nv[2*n+1];
        assign nt[n*TAG_W +: TAG_W]   = take_r ? nt[(2*n+1)*TAG_W +: TAG_W]
                                               : nt[(2*n)*TAG_W +: TAG_W];
        assign ni[n*FLOW_W +: FLOW_W] = take_r ? ni[(2*n+1)*FLOW_W +: FLOW_W]
                                               : ni[(2*n)*FLOW_W +: FLOW_W];
    end

    assign any     = nv[1];
    assign win_idx = ni[FLOW_W +: FLOW_W];
    assign win_tag = nt[TAG_W +: TAG_W];
endmodule

// File: rtl/wfq_sched.sv
// Finish-tag scheduler top. Computes start and finish tags for arrivals,
// keeps one tag queue per flow, and serves the smallest head tag on
// request in the same cycle. Assumes round_now never decreases, tags do
// not wrap within TAG_W, TAG_W >= LEN_W and enq_flow < NUM_FLOWS.
module wfq_sched #(
    parameter int unsigned NUM_FLOWS = 4,
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned LEN_W     = 12,
    parameter int unsigned TAG_W     = 16,
    parameter int unsigned WSH_W     = 3,
    parameter int unsigned FLOW_W    = wfq_pkg::idx_bits(NUM_FLOWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_FLOWS*WSH_W-1:0] weight_log2,
    input  logic [TAG_W-1:0]           round_now,
    input  logic                       enq_valid,
    input  logic [FLOW_W-1:0]          enq_flow,
    input  logic [LEN_W-1:0]           enq_len,
    output logic                       enq_drop,
    input  logic                       deq_req,
    output logic                       deq_valid,
    output logic [FLOW_W-1:0]          deq_flow,
    output logic [TAG_W-1:0]           deq_tag
);
    logic [NUM_FLOWS-1:0]       q_empty, q_full, q_push, q_pop;
    logic [NUM_FLOWS*TAG_W-1:0] q_head;
    logic [TAG_W-1:0]           q_last [NUM_FLOWS];

    logic             sel_empty, sel_full;
    logic [TAG_W-1:0] sel_last, start_tag, finish_tag;
    logic [WSH_W-1:0] sel_shift;
    logic [LEN_W-1:0] scaled_len;
    logic             any_active;

    // Gather the arriving flow's queue state and weight.
    always_comb begin
        sel_empty = 1'b1;
        sel_full  = 1'b0;
        sel_last  = '0;
        sel_shift = '0;
        for (int i = 0; i < NUM_FLOWS; i++) begin
            if (enq_flow == FLOW_W'(i)) begin
                sel_empty = q_empty[i];
                sel_full  = q_full[i];
                sel_last  = q_last[i];
                sel_shift = weight_log2[i*WSH_W +: WSH_W];
            end
        end
    end

    // Start tag by queue state, finish tag by weighted length.
    always_comb begin
        start_tag  = sel_empty ? round_now : sel_last;
        scaled_len = enq_len >> sel_shift;
        finish_tag = start_tag + TAG_W'(scaled_len);
    end

    assign enq_drop  = enq_valid && sel_full;
    assign deq_valid = deq_req && any_active;

    for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_flow
        assign q_push[i] = enq_valid && !sel_full && (enq_flow == FLOW_W'(i));
        assign q_pop[i]  = deq_valid && (deq_flow == FLOW_W'(i));

        wfq_flow_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (q_push[i]),
            .push_tag (finish_tag),
            .pop      (q_pop[i]),
            .head_tag (q_head[i*TAG_W +: TAG_W]),
            .last_fin (q_last[i]),
            .empty    (q_empty[i]),
            .full     (q_full[i])
        );
    end

    wfq_min_select #(.NUM_FLOWS(NUM_FLOWS), .TAG_W(TAG_W), .FLOW_W(FLOW_W)) u_min (
        .vld     (~q_empty),
        .tags    (q_head),
        .any     (any_active),
        .win_idx (deq_flow),
        .win_tag (deq_tag)
    );
endmodule

// File: rtl/wfq_sched_chk.sv
// Protocol checker for wfq_sched. Keeps its own per-flow occupancy from
// the port traffic and relates the grant and drop outputs to it.
module wfq_sched_chk #(
    parameter int unsigned NUM_FLOWS = 4,
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned FLOW_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enq_valid,
    input logic [FLOW_W-1:0] enq_flow,
    input logic              enq_drop,
    input logic              deq_req,
    input logic              deq_valid,
    input logic [FLOW_W-1:0] deq_flow
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] occ [NUM_FLOWS];
    logic             any_busy;

    // Track occupancy per flow from accepted arrivals and grants.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_FLOWS; i++) begin
            if (!rst_n) occ[i] <= '0;
            else begin
                if ((enq_valid && !enq_drop && enq_flow == FLOW_W'(i)) &&
                    !(deq_valid && deq_flow == FLOW_W'(i)))
                    occ[i] <= occ[i] + 1'b1;
                else if (!(enq_valid && !enq_drop && enq_flow == FLOW_W'(i)) &&
                         (deq_valid && deq_flow == FLOW_W'(i)))
                    occ[i] <= occ[i] - 1'b1;
            end
        end
    end

    // Any flow holding packets.
    always_comb begin
        any_busy = 1'b0;
        for (int i = 0; i < NUM_FLOWS; i++) any_busy |= (occ[i] != '0);
    end

    a_r1_r7_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && !any_busy) |-> !deq_valid);
    a_r5_busy_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_req && any_busy) |-> deq_valid);
    a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> deq_req);

    for (genvar i = 0; i < NUM_FLOWS; i++) begin : g_flow_chk
        a_r5_grant_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
            (deq_valid && deq_flow == FLOW_W'(i)) |-> (occ[i] != '0));
        a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            (enq_valid && enq_flow == FLOW_W'(i) && occ[i] == CNT_W'(DEPTH)) |-> enq_drop);
        a_r8_drop_only_full: assert property (@(posedge clk) disable iff (!rst_n)
            (enq_drop && enq_flow == FLOW_W'(i)) |-> (enq_valid && occ[i] == CNT_W'(DEPTH)));
    end
endmodule

bind wfq_sched wfq_sched_chk #(
    .NUM_FLOWS (NUM_FLOWS),
    .DEPTH     (DEPTH),
    .FLOW_W    (FLOW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .enq_flow  (enq_flow),
    .enq_drop  (enq_drop),
    .deq_req   (deq_req),
    .deq_valid (deq_valid),
    .deq_flow  (deq_flow)
);

// File: tb/wfq_sched_bench.sv
// Scoreboard bench: the enqueue driver records expected finish tags per
// flow; each dequeue compares the design's choice with the model.
module wfq_sched_bench;
    localparam int unsigned NF    = 4;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned LEN_W = 12;
    localparam int unsigned TAG_W = 16;
    localparam int unsigned WSH_W = 3;
    localparam int unsigned FW    = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NF*WSH_W-1:0]  weight_log2 = '0;
    logic [TAG_W-1:0]     round_now = '0;
    logic                 enq_valid = 1'b0;
    logic [FW-1:0]        enq_flow = '0;
    logic [LEN_W-1:0]     enq_len = '0;
    logic                 enq_drop;
    logic                 deq_req = 1'b0;
    logic                 deq_valid;
    logic [FW-1:0]        deq_flow;
    logic [TAG_W-1:0]     deq_tag;

    int unsigned exp_q [NF][$];
    int unsigned last_f [NF];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wfq_sched #(.NUM_FLOWS(NF), .DEPTH(DEPTH), .LEN_W(LEN_W), .TAG_W(TAG_W),
                .WSH_W(WSH_W)) u_wfq_sched (
        .clk(clk), .rst_n(rst_n), .weight_log2(weight_log2), .round_now(round_now),
        .enq_valid(enq_valid), .enq_flow(enq_flow), .enq_len(enq_len),
        .enq_drop(enq_drop), .deq_req(deq_req), .deq_valid(deq_valid),
        .deq_flow(deq_flow), .deq_tag(deq_tag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_w(input int f, input int sh);
        weight_log2[f*WSH_W +: WSH_W] = WSH_W'(sh);
    endtask

    // Driver: one arrival, drop checked combinationally, model updated.
    task automatic enq(input int f, input int len, input int rnd);
        int unsigned s, fin, sh;
        bit exp_drop;
        @(negedge clk);
        enq_valid = 1'b1; enq_flow = FW'(f); enq_len = LEN_W'(len);
        round_now = TAG_W'(rnd);
        #1;
        exp_drop = (exp_q[f].size() == DEPTH);
        check(enq_drop == exp_drop, "R8 drop flag", int'(enq_drop), int'(exp_drop));
        sh  = weight_log2[f*WSH_W +: WSH_W];
        s   = (exp_q[f].size() == 0) ? rnd : last_f[f];   // R2 / R3
        fin = (s + (len >> sh)) & ((1 << TAG_W) - 1);     // R4
        @(posedge clk);
        if (!exp_drop) begin
            exp_q[f].push_back(fin);
            last_f[f] = fin;
        end
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    // Monitor: one request, compared to the model's smallest head tag.
    task automatic deq(input string req, input int lit_f = -1, input int lit_t = -1);
        int bf;
        int unsigned bt;
        @(negedge clk);
        deq_req = 1'b1;
        #1;
        bf = -1; bt = 0;
        for (int i = 0; i < NF; i++)
            if (exp_q[i].size() != 0 && (bf < 0 || exp_q[i][0] < bt)) begin
                bf = i; bt = exp_q[i][0];
            end
        check(deq_valid == (bf >= 0), req, int'(deq_valid), int'(bf >= 0));
        if (bf >= 0 && deq_valid) begin
            check(int'(deq_flow) == bf, req, int'(deq_flow), bf);
            check(int'(deq_tag) == int'(bt), req, int'(deq_tag), int'(bt));
        end
        if (lit_f >= 0) check(int'(deq_flow) == lit_f, req, int'(deq_flow), lit_f);
        if (lit_t >= 0) check(int'(deq_tag) == lit_t, req, int'(deq_tag), lit_t);
        @(posedge clk);
        if (bf >= 0) void'(exp_q[bf].pop_front());
        @(negedge clk);
        deq_req = 1'b0;
    endtask

    initial begin
        int rnd;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 / R7: nothing queued after reset.
        deq("R1 reset empty");
        deq("R7 idle request");

        // R2, R3, R4, R5: mixed weights.
        set_w(1, 1);
        enq(0, 100, 10);                 // 10+100 = 110
        enq(1, 64, 10);                  // 10+32  = 42
        enq(0, 20, 30);                  // 110+20 = 130 (R3)
        deq("R5 smallest", 1, 42);
        deq("R2 empty start", 0, 110);
        deq("R3 chained start", 0, 130);
        deq("R7 drained");

        // R6: equal tags at both tree levels.
        set_w(1, 0); set_w(2, 2);
        enq(3, 4, 0);                    // 4
        enq(2, 16, 0);                   // 16>>2 = 4
        enq(1, 4, 0);                    // 4
        deq("R6 tie lower index", 1, 4);
        deq("R6 tie lower index", 2, 4);
        deq("R6 tie lower index", 3, 4);

        // R8 full queue, R9 order within a flow.
        enq(0, 1, 50); enq(0, 1, 50); enq(0, 1, 50); enq(0, 1, 50);
        enq(0, 1, 50);                   // dropped
        deq("R9 fifo order", 0, 51);
        deq("R9 fifo order", 0, 52);
        deq("R9 fifo order", 0, 53);
        deq("R9 fifo order", 0, 54);
        deq("R7 drained");
        // R9: drained flow restarts at round_now, not at last finish 54.
        enq(0, 8, 5);
        deq("R9 restart at round", 0, 13);

        // Mixed random traffic with a rising round number.
        for (int w = 0; w < NF; w++) set_w(w, w);
        rnd = 100;
        for (int k = 0; k < 400; k++) begin
            rnd += $urandom_range(0, 6);
            if ($urandom_range(0, 2) != 0) enq($urandom_range(0, NF - 1), $urandom_range(0, 255), rnd);
            else deq("R5 random order");
        end
        for (int k = 0; k < NF * DEPTH + 1; k++) deq("R5 drain");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule